// File: doc/BRIEF.md
# Configurable parallel-to-serial transmitter

This block turns a parallel transmit word into a serial bit stream, one bit per clock. A word is either 16 lanes wide or 4 lanes narrow, chosen by a mode input, and a bit-order input decides whether the lowest lane or the highest active lane leaves first. The block asks for each new word with a one-cycle load strobe. Upstream logic holds the next word steady on the parallel input during that cycle.

Two overrides sit in front of the serial output register. An active-low squelch forces the output to a constant zero. An active-low line-loopback input replaces the transmit stream with a receive-side serial bit, delayed by one register stage. While loopback is active, the squelch has no effect. Mode and bit order are sampled only at the capture cycle, so a change to either one applies from the next word and never splits a word.

Top module: `par2ser_tx`

## Requirements
- R1: With `wideMode` low, each word is 4 bits long, is taken from lanes 0 to 3 only, and `loadStrobe` pulses once every 4 clocks.
- R2: With `wideMode` high, each word is 16 bits long, uses lanes 0 to 15, and `loadStrobe` pulses once every 16 clocks.
- R3: With `msbFirst` low, lane 0 is sent first and the lanes follow in ascending index order.
- R4: With `msbFirst` high, the highest active lane is sent first (lane 15 when wide, lane 3 when narrow) and the lanes follow in descending order down to lane 0.
- R5: `txWord` is captured at the rising edge that ends a cycle in which `loadStrobe` is high. Its first serial bit appears on `serOut` after the next rising edge, and the following bits appear one per clock after that.
- R6: `wideMode` and `msbFirst` are sampled only in the capture cycle. Changing either one during a word leaves that word's length and order unchanged.
- R7: With `loopbackN` high and `squelchN` low at a rising edge, `serOut` is 0 after that edge.
- R8: With `loopbackN` low at a rising edge, `serOut` after that edge equals the `loopData` value sampled at that edge, whatever the value of `squelchN`.
- R9: Synchronous active-high `rst` holds `serOut` at 0 and `loadStrobe` low. The first cycle after reset is released is a capture cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst | input | 1 | Synchronous reset, active high |
| txWord | input | 16 | Parallel transmit word, one bit per lane |
| wideMode | input | 1 | 1: 16-lane words, 0: 4-lane words |
| msbFirst | input | 1 | 1: highest active lane first, 0: lane 0 first |
| squelchN | input | 1 | Active-low output squelch |
| loopbackN | input | 1 | Active-low line loopback enable |
| loopData | input | 1 | Recovered receive serial bit forwarded in loopback |
| loadStrobe | output | 1 | High in the cycle whose closing edge captures `txWord` |
| serOut | output | 1 | Registered serial output |

## Verification
The assertions assume that every input is a known level at each rising edge and that `rst` is asserted from time zero. A loopback or squelch level sampled at one edge is taken to decide the output for the following cycle only. The bench changes inputs one time unit after the falling edge. It never leaves a control input unknown, and it deliberately flips mode and bit order in the middle of words to exercise the word-boundary rule. The strobe-spacing property relies on the mode having been sampled at the previous capture. The bench keeps that true by changing mode freely between captures and letting the design latch it.

// File: rtl/par2ser_pkg.sv
package par2ser_pkg;

  // Control-to-datapath strobes for one serial clock
  typedef struct packed {
    logic load;   // capture a fresh word into the shifter
    logic shift;  // advance the shifter by one lane
  } ctrlStrobe_t;

endpackage

// File: rtl/par2ser_ctrl.sv
module par2ser_ctrl
  import par2ser_pkg::*;
#(
  parameter int WIDE   = 16,
  parameter int NARROW = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wideMode,
  output ctrlStrobe_t strobes
);

  localparam int CNT_W = $clog2(WIDE);
  localparam logic [CNT_W-1:0] WIDE_LAST   = CNT_W'(WIDE - 1);
  localparam logic [CNT_W-1:0] NARROW_LAST = CNT_W'(NARROW - 1);

  logic [CNT_W-1:0] bitsLeft;

  // Counts down the bits remaining in the current word; mode sampled at wrap
  always_ff @(posedge clk) begin
    if (rst) begin
      bitsLeft <= '0;
    end else if (bitsLeft == '0) begin
      bitsLeft <= wideMode ? WIDE_LAST : NARROW_LAST;
    end else begin
      bitsLeft <= bitsLeft - 1'b1;
    end
  end

  always_comb begin
    strobes.load  = !rst && (bitsLeft == '0);
    strobes.shift = !rst && (bitsLeft != '0);
  end

endmodule

// File: rtl/par2ser_dp.sv
module par2ser_dp
  import par2ser_pkg::*;
#(
  parameter int WIDE   = 16,
  parameter int NARROW = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  ctrlStrobe_t     strobes,
  input  logic [WIDE-1:0] txWord,
  input  logic            wideMode,
  input  logic            msbFirst,
  input  logic            squelchN,
  input  logic            loopbackN,
  input  logic            loopData,
  output logic            serOut
);

  logic [WIDE-1:0] wideSeq;
  logic [WIDE-1:0] narrowSeq;
  logic [WIDE-1:0] shifter;

  // Reorder lanes so that bit i of the sequence is the i-th bit on the wire
  for (genvar i = 0; i < WIDE; i++) begin : g_order
    assign wideSeq[i] = msbFirst ? txWord[WIDE-1-i] : txWord[i];
    if (i < NARROW) begin : g_narrowLane
      assign narrowSeq[i] = msbFirst ? txWord[NARROW-1-i] : txWord[i];
    end else begin : g_narrowPad
      assign narrowSeq[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shifter <= '0;
    end else if (strobes.load) begin
      shifter <= wideMode ? wideSeq : narrowSeq;
    end else if (strobes.shift) begin
      shifter <= shifter >> 1;
    end
  end

  // Output stage: loopback overrides squelch, squelch overrides data
  always_ff @(posedge clk) begin
    if (rst) begin
      serOut <= 1'b0;
    end else if (!loopbackN) begin
      serOut <= loopData;
    end else if (!squelchN) begin
      serOut <= 1'b0;
    end else begin
      serOut <= shifter[0];
    end
  end

endmodule

// File: rtl/par2ser_tx.sv
module par2ser_tx
  import par2ser_pkg::*;
#(
  parameter int WIDE   = 16,
  parameter int NARROW = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [WIDE-1:0] txWord,
  input  logic            wideMode,
  input  logic            msbFirst,
  input  logic            squelchN,
  input  logic            loopbackN,
  input  logic            loopData,
  output logic            loadStrobe,
  output logic            serOut
);

  ctrlStrobe_t strobes;

  par2ser_ctrl #(.WIDE(WIDE), .NARROW(NARROW)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .wideMode (wideMode),
    .strobes  (strobes)
  );

  par2ser_dp #(.WIDE(WIDE), .NARROW(NARROW)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .txWord    (txWord),
    .wideMode  (wideMode),
    .msbFirst  (msbFirst),
    .squelchN  (squelchN),
    .loopbackN (loopbackN),
    .loopData  (loopData),
    .serOut    (serOut)
  );

  assign loadStrobe = strobes.load;

endmodule

// File: rtl/par2ser_chk.sv
module par2ser_chk #(
  parameter int WIDE   = 16,
  parameter int NARROW = 4
) (
  input logic clk,
  input logic rst,
  input logic wideMode,
  input logic squelchN,
  input logic loopbackN,
  input logic loopData,
  input logic loadStrobe,
  input logic serOut
);

  localparam int GAP_W = $clog2(WIDE) + 2;

  logic [GAP_W-1:0] sinceLoad;
  logic             seenLoad;
  logic             lastWide;

  // Clocks elapsed since the previous capture, and the mode it latched
  always_ff @(posedge clk) begin
    if (rst) begin
      sinceLoad <= '0;
      seenLoad  <= 1'b0;
      lastWide  <= 1'b0;
    end else if (loadStrobe) begin
      sinceLoad <= GAP_W'(1);
      seenLoad  <= 1'b1;
      lastWide  <= wideMode;
    end else begin
      sinceLoad <= sinceLoad + 1'b1;
    end
  end

  // R1 and R2: strobe period follows the mode latched at the previous capture
  assert_strobe_period_R1: assert property (@(posedge clk) disable iff (rst)
    (loadStrobe && seenLoad) |-> (sinceLoad == (lastWide ? GAP_W'(WIDE) : GAP_W'(NARROW))));

  // R2: a strobe is never followed directly by another
  assert_strobe_gap_R2: assert property (@(posedge clk) disable iff (rst)
    loadStrobe |=> !loadStrobe);

  assert_squelch_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (loopbackN && !squelchN) |=> !serOut);

  assert_loop_path_R8: assert property (@(posedge clk) disable iff (rst)
    !loopbackN |=> (serOut == $past(loopData)));

  assert_reset_quiet_R9: assert property (@(posedge clk)
    rst |=> !serOut);

  assert_reset_nostrobe_R9: assert property (@(posedge clk)
    rst |-> !loadStrobe);

endmodule

bind par2ser_tx par2ser_chk #(.WIDE(WIDE), .NARROW(NARROW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wideMode   (wideMode),
  .squelchN   (squelchN),
  .loopbackN  (loopbackN),
  .loopData   (loopData),
  .loadStrobe (loadStrobe),
  .serOut     (serOut)
);

// File: tb/test_par2ser_tx.sv
`timescale 1ns/1ps
module test_par2ser_tx;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] txWord = '0;
  logic        wideMode = 1'b0;
  logic        msbFirst = 1'b0;
  logic        squelchN = 1'b1;
  logic        loopbackN = 1'b1;
  logic        loopData = 1'b0;
  logic        loadStrobe;
  logic        serOut;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  par2ser_tx i_par2ser_tx (
    .clk(clk), .rst(rst), .txWord(txWord), .wideMode(wideMode),
    .msbFirst(msbFirst), .squelchN(squelchN), .loopbackN(loopbackN),
    .loopData(loopData), .loadStrobe(loadStrobe), .serOut(serOut)
  );

  // Behavioural reference: queue of pending wire bits and a bit countdown
  bit    mQ[$];
  string mTag[$];
  int    mLeft = 0;
  bit    expSer = 0;
  string serTag = "R9";
  bit    started = 0;

  always @(posedge clk) begin
    started <= 1;
    if (rst) begin
      expSer = 0;
      serTag = "R9";
      mQ.delete();
      mTag.delete();
      mLeft = 0;
    end else begin
      bit    cur;
      string curTag;
      cur    = (mQ.size() > 0) ? mQ[0] : 1'b0;
      curTag = (mTag.size() > 0) ? mTag[0] : "R9";
      if (!loopbackN) begin
        expSer = loopData;
        serTag = "R8";
      end else if (!squelchN) begin
        expSer = 0;
        serTag = "R7";
      end else begin
        expSer = cur;
        serTag = curTag;
      end
      if (mLeft == 0) begin
        int len;
        string t;
        len = wideMode ? 16 : 4;
        t = $sformatf("%s %s R5 R6", wideMode ? "R2" : "R1", msbFirst ? "R4" : "R3");
        mQ.delete();
        mTag.delete();
        for (int k = 0; k < len; k++) begin
          mQ.push_back(msbFirst ? txWord[len-1-k] : txWord[k]);
          mTag.push_back(t);
        end
        mLeft = len - 1;
      end else begin
        if (mQ.size() > 0) begin
          void'(mQ.pop_front());
          void'(mTag.pop_front());
        end
        mLeft--;
      end
    end
  end

  // Compare away from the active edge
  always @(negedge clk) begin
    if (started && !done) begin
      bit expLoad;
      expLoad = !rst && (mLeft == 0);
      compared++;
      if (serOut !== expSer) begin
        mismatched++;
        $display("FAIL %s serOut actual=%b expected=%b at %0t", serTag, serOut, expSer, $time);
      end
      compared++;
      if (loadStrobe !== expLoad) begin
        mismatched++;
        $display("FAIL %s loadStrobe actual=%b expected=%b at %0t",
                 rst ? "R9" : "R5", loadStrobe, expLoad, $time);
      end
    end
  end

  task automatic finishRun();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  task automatic runPhase(input int cycles, input bit w, input bit m,
                          input bit sq, input bit lb, input bit toggle);
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      #1;
      txWord   = 16'($urandom);
      loopData = 1'($urandom);
      if (c == 0) begin
        wideMode = w; msbFirst = m; squelchN = sq; loopbackN = lb;
      end
      // R6: flip mode and order at odd points inside words
      if (toggle && (c % 7 == 3)) wideMode = 1'($urandom);
      if (toggle && (c % 5 == 2)) msbFirst = 1'($urandom);
    end
  endtask

  initial begin
    // R9: reset state
    repeat (3) @(negedge clk);
    #1 rst = 0;
    runPhase(40, 0, 0, 1, 1, 0);   // R1 R3 narrow, lane 0 first
    runPhase(40, 0, 1, 1, 1, 0);   // R1 R4 narrow, lane 3 first
    runPhase(96, 1, 0, 1, 1, 0);   // R2 R3 wide, ascending
    runPhase(96, 1, 1, 1, 1, 0);   // R2 R4 wide, descending
    runPhase(30, 1, 0, 0, 1, 0);   // R7 squelch
    runPhase(30, 0, 1, 0, 0, 0);   // R8 loopback overrides squelch
    runPhase(30, 1, 1, 1, 0, 0);   // R8 loopback, squelch released
    runPhase(250, 0, 0, 1, 1, 1);  // R6 mid-word changes
    @(negedge clk); #1 rst = 1;    // R9 mid-run reset
    repeat (2) @(negedge clk);
    #1 rst = 0;
    runPhase(60, 1, 1, 1, 1, 1);   // R9 first cycle after release is a capture
    runPhase(20, 0, 0, 0, 1, 0);   // R7
    finishRun();
  end

  initial begin
    #(200000 * 8);
    mismatched++;
    $display("FAIL watchdog expired at %0t", $time);
    finishRun();
  end

endmodule